// File: doc/BRIEF.md
# Mailbox Power-Cap Command Engine

This engine services a command/response mailbox that a host places in shared memory. On every poll tick it reads the command area through a byte-wide memory port, and if a command is waiting it moves the command through a one-tick in-progress step before answering. The only command carried out is the one that sets the power cap. The engine checks the length of its data, clamps the value to fixed limits, keeps the current cap and cap type in its own registers and mirrors them into a header area of the mailbox.

A response is built field by field: request id, command code, status, big-endian length and any data are written first. The response-ready flag follows, then the command flag is cleared, and only then does the engine pulse a message event towards the interrupt logic. After reset the engine writes the header (state, cap type and the four cap values) before it accepts any tick. The mailbox sits at a configurable base address with fixed offsets: header at +0x00, command buffer at +0x10, response buffer at +0x20.

Top module: `mbx_engine`

## Requirements
- R1: After reset the engine writes the header bytes, most-significant byte first: +0x00 state 0x03, +0x01 cap type 0x00, +0x02/+0x03 hard minimum 10, +0x04/+0x05 maximum 100, +0x06/+0x07 current cap 100, +0x08/+0x09 soft minimum 20. It then reports cap 100 with type 0x00.
- R2: A poll tick acts on a command only when the command flag byte (+0x10) equals 0x80. Any other value leaves the mailbox unchanged and raises no event.
- R3: When a command is pending and the response flag (+0x20) is 0x00, the engine writes only 0x02 to the response flag and raises no event. The command is answered on the next tick.
- R4: When a command is pending and the response flag is neither 0x00 nor 0x02, the engine answers at once with status 0x15 and data length 0, and the cap is left unchanged.
- R5: Command code 0xD1 with a 16-bit length (+0x14 high, +0x15 low) other than 2 is answered with status 0x12 and 2 data bytes holding the unchanged current cap.
- R6: Code 0xD1 of length 2 with a value of 0 (+0x16 high, +0x17 low) sets cap type 0x00 and cap 100, with status 0x00.
- R7: Code 0xD1 of length 2 with a nonzero value sets cap type 0x02 and a cap clamped into 10..100, with status 0x00. The response data is the new cap.
- R8: Any command code other than 0xD1 is answered with status 0x11 and data length 0.
- R9: The response holds request id (+0x21) and command code (+0x22) copied from +0x11 and +0x12, status at +0x23, length at +0x24/+0x25 high byte first, and data from +0x26, high byte first.
- R10: The response fields are written first. Then the response flag is set to 0x01, then the command flag is cleared to 0x00, then a message event of one cycle follows.
- R11: A tick that arrives while the engine is busy is held and serviced once the engine is idle.
- R12: Busy is high during the header write after reset and for every poll sequence. The memory port is never requested while busy is low.
- R13: After every response the header cap type (+0x01) and current cap (+0x06/+0x07) match the engine's cap outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Poll tick request |
| busy_o | output | 1 | Memory sequence in progress |
| msg_evt_o | output | 1 | One-cycle message event after a response |
| cap_o | output | 16 | Current power cap in watts |
| cap_type_o | output | 8 | Current cap type code |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read request |

## Verification
A wrong sequencer state shows up within one poll as a missing or misplaced byte in the response area, or as a flag written out of order. The engine might also answer a command that was not pending, or skip the in-progress step. A fault in the cap registers or the clamp shows up on the cap outputs and in the mirrored header right after the response that used it. The status and data of the next length-error response then repeat the wrong value. Port-level ordering of the flag writes and the event, and the absence of memory traffic while idle, are watched on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // byte offsets of the three mailbox areas from the base address
  localparam int HDR_OFS = 0;
  localparam int CMD_OFS = 16;
  localparam int RSP_OFS = 32;

  // flag and code values
  localparam logic [7:0] CMD_READY   = 8'h80;
  localparam logic [7:0] RSP_BUSY    = 8'h02;
  localparam logic [7:0] RSP_DONE    = 8'h01;
  localparam logic [7:0] CODE_SETCAP = 8'hD1;

  localparam logic [7:0] ST_OK      = 8'h00;
  localparam logic [7:0] ST_BADCODE = 8'h11;
  localparam logic [7:0] ST_BADLEN  = 8'h12;
  localparam logic [7:0] ST_INTERR  = 8'h15;

  localparam logic [7:0] TYPE_NONE = 8'h00;
  localparam logic [7:0] TYPE_USER = 8'h02;

  typedef enum logic [2:0] {
    S_INIT,
    S_IDLE,
    S_RD,
    S_RDW,
    S_PROG,
    S_APPLY,
    S_WR,
    S_EVT
  } seq_state_e;
endpackage

// File: rtl/mbx_tick_latch.sv
module mbx_tick_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (tick_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/mbx_cap.sv
module mbx_cap
  import mbx_pkg::*;
#(
  parameter logic [15:0] CAP_HARD = 16'd10,
  parameter logic [15:0] CAP_MAX  = 16'd100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        apply_i,
  input  logic        err_i,
  input  logic [7:0]  code_i,
  input  logic [15:0] len_i,
  input  logic [15:0] val_i,
  output logic [7:0]  status_o,
  output logic        has_data_o,
  output logic [15:0] cap_o,
  output logic [7:0]  type_o
);
  logic [15:0] cap_q, cap_d;
  logic [7:0]  type_q, type_d;
  logic        upd_en;
  logic        len_ok;

  assign len_ok = (len_i == 16'd2);

  // status and data presence decoded from the captured command
  always_comb begin
    status_o   = ST_OK;
    has_data_o = 1'b0;
    upd_en     = 1'b0;
    if (err_i) begin
      status_o = ST_INTERR;
    end else if (code_i != CODE_SETCAP) begin
      status_o = ST_BADCODE;
    end else if (!len_ok) begin
      status_o   = ST_BADLEN;
      has_data_o = 1'b1;
    end else begin
      has_data_o = 1'b1;
      upd_en     = apply_i;
    end
  end

  // clamp of the requested value
  always_comb begin
    if (val_i == 16'd0) begin
      cap_d  = CAP_MAX;
      type_d = TYPE_NONE;
    end else if (val_i < CAP_HARD) begin
      cap_d  = CAP_HARD;
      type_d = TYPE_USER;
    end else if (val_i > CAP_MAX) begin
      cap_d  = CAP_MAX;
      type_d = TYPE_USER;
    end else begin
      cap_d  = val_i;
      type_d = TYPE_USER;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= CAP_MAX;
      type_q <= TYPE_NONE;
    end else if (upd_en) begin
      cap_q  <= cap_d;
      type_q <= type_d;
    end
  end

  assign cap_o  = cap_q;
  assign type_o = type_q;
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h080,
  parameter logic [7:0]  STATE_ACT = 8'h03,
  parameter logic [15:0] CAP_HARD  = 16'd10,
  parameter logic [15:0] CAP_MAX   = 16'd100,
  parameter logic [15:0] CAP_SOFT  = 16'd20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_i,
  output logic              take_o,
  output logic              busy_o,
  output logic              evt_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              apply_o,
  output logic              err_o,
  output logic [7:0]        code_o,
  output logic [15:0]       len_o,
  output logic [15:0]       val_o,
  input  logic [7:0]        status_i,
  input  logic              has_data_i,
  input  logic [15:0]       cap_i,
  input  logic [7:0]        type_i
);
  localparam int NFLD     = 8;
  localparam int IDX_W    = 4;
  localparam int INIT_LST = 9;
  localparam int RD_LST   = NFLD - 1;
  localparam int WR_LST   = 11;

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             err_q, err_d, err_en;
  logic             cap_en;
  logic [7:0]       fld_q [NFLD];

  function automatic logic [ADDR_W-1:0] at(input int ofs);
    return BASE + ADDR_W'(ofs);
  endfunction

  // header byte written during initialisation
  function automatic logic [7:0] init_byte(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    return STATE_ACT;
      4'd1:    return TYPE_NONE;
      4'd2:    return CAP_HARD[15:8];
      4'd3:    return CAP_HARD[7:0];
      4'd4:    return CAP_MAX[15:8];
      4'd5:    return CAP_MAX[7:0];
      4'd6:    return CAP_MAX[15:8];
      4'd7:    return CAP_MAX[7:0];
      4'd8:    return CAP_SOFT[15:8];
      default: return CAP_SOFT[7:0];
    endcase
  endfunction

  // command byte read at each step of the read phase
  function automatic logic [ADDR_W-1:0] rd_addr(input logic [IDX_W-1:0] i);
    case (i)
      4'd0:    return at(CMD_OFS + 0);
      4'd1:    return at(RSP_OFS + 0);
      4'd2:    return at(CMD_OFS + 1);
      4'd3:    return at(CMD_OFS + 2);
      4'd4:    return at(CMD_OFS + 4);
      4'd5:    return at(CMD_OFS + 5);
      4'd6:    return at(CMD_OFS + 6);
      default: return at(CMD_OFS + 7);
    endcase
  endfunction

  assign code_o = fld_q[3];
  assign len_o  = {fld_q[4], fld_q[5]};
  assign val_o  = {fld_q[6], fld_q[7]};
  assign err_o  = err_q;

  // next-state and port logic
  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    err_d       = err_q;
    err_en      = 1'b0;
    cap_en      = 1'b0;
    take_o      = 1'b0;
    evt_o       = 1'b0;
    apply_o     = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = BASE;
    mem_wdata_o = 8'h00;

    unique case (state_q)
      S_INIT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = at(HDR_OFS) + ADDR_W'(idx_q);
        mem_wdata_o = init_byte(idx_q);
        if (idx_q == IDX_W'(INIT_LST)) begin
          idx_d   = '0;
          state_d = S_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end

      S_IDLE: begin
        if (pend_i) begin
          take_o  = 1'b1;
          idx_d   = '0;
          state_d = S_RD;
        end
      end

      S_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = rd_addr(idx_q);
        state_d    = S_RDW;
      end

      S_RDW: begin
        cap_en = 1'b1;
        if (idx_q == 4'd0 && mem_rdata_i != CMD_READY) begin
          state_d = S_IDLE;
        end else if (idx_q == 4'd1 && mem_rdata_i == 8'h00) begin
          state_d = S_PROG;
        end else if (idx_q == IDX_W'(RD_LST)) begin
          state_d = S_APPLY;
        end else begin
          if (idx_q == 4'd1) begin
            err_en = 1'b1;
            err_d  = (mem_rdata_i != RSP_BUSY);
          end
          idx_d   = idx_q + 1'b1;
          state_d = S_RD;
        end
      end

      S_PROG: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = at(RSP_OFS + 0);
        mem_wdata_o = RSP_BUSY;
        state_d     = S_IDLE;
      end

      S_APPLY: begin
        apply_o = 1'b1;
        idx_d   = '0;
        state_d = S_WR;
      end

      S_WR: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        case (idx_q)
          4'd0:  begin mem_addr_o = at(RSP_OFS + 1); mem_wdata_o = fld_q[2]; end
          4'd1:  begin mem_addr_o = at(RSP_OFS + 2); mem_wdata_o = fld_q[3]; end
          4'd2:  begin mem_addr_o = at(RSP_OFS + 3); mem_wdata_o = status_i; end
          4'd3:  begin mem_addr_o = at(RSP_OFS + 4); mem_wdata_o = 8'h00; end
          4'd4:  begin mem_addr_o = at(RSP_OFS + 5); mem_wdata_o = has_data_i ? 8'd2 : 8'd0; end
          4'd5:  begin mem_addr_o = at(RSP_OFS + 6); mem_wdata_o = cap_i[15:8]; end
          4'd6:  begin mem_addr_o = at(RSP_OFS + 7); mem_wdata_o = cap_i[7:0]; end
          4'd7:  begin mem_addr_o = at(HDR_OFS + 1); mem_wdata_o = type_i; end
          4'd8:  begin mem_addr_o = at(HDR_OFS + 6); mem_wdata_o = cap_i[15:8]; end
          4'd9:  begin mem_addr_o = at(HDR_OFS + 7); mem_wdata_o = cap_i[7:0]; end
          4'd10: begin mem_addr_o = at(RSP_OFS + 0); mem_wdata_o = RSP_DONE; end
          default: begin mem_addr_o = at(CMD_OFS + 0); mem_wdata_o = 8'h00; end
        endcase
        if (idx_q == IDX_W'(WR_LST)) begin
          state_d = S_EVT;
        end else if (idx_q == 4'd4 && !has_data_i) begin
          idx_d = 4'd7;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end

      S_EVT: begin
        evt_o   = 1'b1;
        state_d = S_IDLE;
      end

      default: state_d = S_IDLE;
    endcase
  end

  assign busy_o = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_INIT;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              fld_q[g] <= 8'h00;
      else if (cap_en && idx_q == IDX_W'(g))   fld_q[g] <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/mbx_engine.sv
module mbx_engine
  import mbx_pkg::*;
#(
  parameter int          ADDR_W    = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h080,
  parameter logic [7:0]  STATE_ACT = 8'h03,
  parameter logic [15:0] CAP_HARD  = 16'd10,
  parameter logic [15:0] CAP_MAX   = 16'd100,
  parameter logic [15:0] CAP_SOFT  = 16'd20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              msg_evt_o,
  output logic [15:0]       cap_o,
  output logic [7:0]        cap_type_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  logic [1:0]  rst_sync_q;
  logic        rst_sync_n;
  logic        pend, take, apply, err, has_data;
  logic [7:0]  code, status;
  logic [15:0] len, val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  mbx_tick_latch u_tick (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick_i),
    .take_i (take),
    .pend_o (pend)
  );

  mbx_cap #(
    .CAP_HARD (CAP_HARD),
    .CAP_MAX  (CAP_MAX)
  ) u_cap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .apply_i    (apply),
    .err_i      (err),
    .code_i     (code),
    .len_i      (len),
    .val_i      (val),
    .status_o   (status),
    .has_data_o (has_data),
    .cap_o      (cap_o),
    .type_o     (cap_type_o)
  );

  mbx_seq #(
    .ADDR_W    (ADDR_W),
    .BASE      (BASE),
    .STATE_ACT (STATE_ACT),
    .CAP_HARD  (CAP_HARD),
    .CAP_MAX   (CAP_MAX),
    .CAP_SOFT  (CAP_SOFT)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pend_i      (pend),
    .take_o      (take),
    .busy_o      (busy_o),
    .evt_o       (msg_evt_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .apply_o     (apply),
    .err_o       (err),
    .code_o      (code),
    .len_o       (len),
    .val_o       (val),
    .status_i    (status),
    .has_data_i  (has_data),
    .cap_i       (cap_o),
    .type_i      (cap_type_o)
  );
endmodule

// File: rtl/mbx_engine_chk.sv
module mbx_engine_chk
  import mbx_pkg::*;
#(
  parameter int          ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h080,
  parameter logic [15:0] CAP_HARD = 16'd10,
  parameter logic [15:0] CAP_MAX  = 16'd100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              msg_evt_o,
  input logic [15:0]       cap_o,
  input logic [7:0]        cap_type_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [7:0]        mem_wdata_o
);
  localparam logic [ADDR_W-1:0] CMD_A = BASE + ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] RSP_A = BASE + ADDR_W'(RSP_OFS);

  logic clr_wr, rdy_wr, saw_rdy_q;

  assign clr_wr = mem_req_o && mem_we_o && mem_addr_o == CMD_A && mem_wdata_o == 8'h00;
  assign rdy_wr = mem_req_o && mem_we_o && mem_addr_o == RSP_A && mem_wdata_o == RSP_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         saw_rdy_q <= 1'b0;
    else if (rdy_wr)    saw_rdy_q <= 1'b1;
    else if (msg_evt_o) saw_rdy_q <= 1'b0;
  end

  assert_req_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> busy_o);

  assert_evt_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_evt_o |=> !msg_evt_o);

  assert_evt_after_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_evt_o |-> $past(clr_wr));

  assert_clear_after_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |-> saw_rdy_q);

  assert_cap_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o >= CAP_HARD && cap_o <= CAP_MAX);

  assert_type_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_type_o == TYPE_NONE |-> cap_o == CAP_MAX);

  assert_cap_changes_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_o) |-> $past(busy_o));
endmodule

bind mbx_engine mbx_engine_chk #(
  .ADDR_W   (ADDR_W),
  .BASE     (BASE),
  .CAP_HARD (CAP_HARD),
  .CAP_MAX  (CAP_MAX)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .busy_o      (busy_o),
  .msg_evt_o   (msg_evt_o),
  .cap_o       (cap_o),
  .cap_type_o  (cap_type_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/mbx_engine_tb.sv
module mbx_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 10;
  localparam int BASE = 'h080;
  localparam int HDR  = BASE;
  localparam int CMD  = BASE + 16;
  localparam int RSP  = BASE + 32;
  localparam int NV   = 13;

  typedef struct packed {
    logic [7:0]  cflag;
    logic [7:0]  rflag;
    logic [7:0]  code;
    logic [15:0] len;
    logic [15:0] val;
    logic [7:0]  st;
    logic [7:0]  rlen;
    logic [15:0] cap;
    logic [7:0]  typ;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'h80, 8'h00, 8'hD1, 16'd2,     16'd50,  8'h00, 8'd2, 16'd50,  8'h02}, // R7 in range
    '{8'h80, 8'h00, 8'hD1, 16'd3,     16'd0,   8'h12, 8'd2, 16'd50,  8'h02}, // R5 bad length
    '{8'h80, 8'h00, 8'hD1, 16'd2,     16'd0,   8'h00, 8'd2, 16'd100, 8'h00}, // R6 clear
    '{8'h80, 8'h00, 8'hD1, 16'd2,     16'd5,   8'h00, 8'd2, 16'd10,  8'h02}, // R7 low clamp
    '{8'h80, 8'h00, 8'hD1, 16'd2,     16'd300, 8'h00, 8'd2, 16'd100, 8'h02}, // R7 high clamp
    '{8'h80, 8'h00, 8'hD1, 16'd2,     16'd10,  8'h00, 8'd2, 16'd10,  8'h02}, // R7 lower edge
    '{8'h80, 8'h00, 8'hD1, 16'd2,     16'd100, 8'h00, 8'd2, 16'd100, 8'h02}, // R7 upper edge
    '{8'h80, 8'h00, 8'h42, 16'd0,     16'd0,   8'h11, 8'd0, 16'd100, 8'h02}, // R8 unknown
    '{8'h80, 8'h07, 8'hD1, 16'd2,     16'd50,  8'h15, 8'd0, 16'd100, 8'h02}, // R4 bad flag
    '{8'h81, 8'h00, 8'hD1, 16'd2,     16'd50,  8'h00, 8'd0, 16'd100, 8'h02}, // R2 ignored
    '{8'h00, 8'h00, 8'hD1, 16'd2,     16'd50,  8'h00, 8'd0, 16'd100, 8'h02}, // R2 ignored
    '{8'h80, 8'h02, 8'hD1, 16'd2,     16'd99,  8'h00, 8'd2, 16'd99,  8'h02}, // R3 already busy
    '{8'h80, 8'h00, 8'hD1, 16'h0102,  16'd0,   8'h12, 8'd2, 16'd99,  8'h02}  // R5 length high
  };

  logic          clk, rst_n, tick;
  logic          busy, evt, mreq, mwe;
  logic [15:0]   cap;
  logic [7:0]    ctype, mwd, mrd;
  logic [AW-1:0] maddr;
  logic          h_we;
  logic [AW-1:0] h_addr;
  logic [7:0]    h_data;
  logic [7:0]    mem [1 << AW];

  int n_chk, n_fail, ev_cnt, cyc, viol;
  int t_rdy, t_clr, t_dat, t_evt;
  bit done;

  mbx_engine u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .busy_o      (busy),
    .msg_evt_o   (evt),
    .cap_o       (cap),
    .cap_type_o  (ctype),
    .mem_req_o   (mreq),
    .mem_we_o    (mwe),
    .mem_addr_o  (maddr),
    .mem_wdata_o (mwd),
    .mem_rdata_i (mrd)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // shared memory model with a host write port
  always @(posedge clk) begin
    if (mreq && mwe)  mem[maddr] <= mwd;
    else if (mreq)    mrd <= mem[maddr];
    if (h_we)         mem[h_addr] <= h_data;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (evt) begin
      ev_cnt <= ev_cnt + 1;
      t_evt  <= cyc;
    end
    if (mreq && mwe) begin
      if (int'(maddr) == RSP && mwd == 8'h01) t_rdy <= cyc;
      if (int'(maddr) == CMD && mwd == 8'h00) t_clr <= cyc;
      if (int'(maddr) > RSP && int'(maddr) <= RSP + 7) t_dat <= cyc;
    end
  end

  always @(negedge clk) if (rst_n && mreq && !busy) viol <= viol + 1;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic hwr(input int a, input logic [7:0] d);
    @(negedge clk);
    h_we = 1'b1; h_addr = AW'(a); h_data = d;
    @(negedge clk);
    h_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic poll();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (2) @(negedge clk);
    wait_idle();
    @(negedge clk);
  endtask

  task automatic load(input vec_t v, input logic [7:0] rid);
    hwr(RSP, v.rflag);
    hwr(CMD + 1, rid);
    hwr(CMD + 2, v.code);
    hwr(CMD + 3, 8'h00);
    hwr(CMD + 4, v.len[15:8]);
    hwr(CMD + 5, v.len[7:0]);
    hwr(CMD + 6, v.val[15:8]);
    hwr(CMD + 7, v.val[7:0]);
    hwr(CMD, v.cflag);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; ev_cnt = 0; cyc = 0; viol = 0;
    t_rdy = 0; t_clr = 0; t_dat = 0; t_evt = 0; done = 0;
    tick = 1'b0; h_we = 1'b0; h_addr = '0; h_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 busy after reset", int'(busy), 1);
    wait_idle();
    @(negedge clk);
    // R1 header contents after initialisation
    chk("R1 state", mem[HDR + 0], 8'h03);
    chk("R1 cap type", mem[HDR + 1], 8'h00);
    chk("R1 hard min", {mem[HDR + 2], mem[HDR + 3]}, 10);
    chk("R1 max", {mem[HDR + 4], mem[HDR + 5]}, 100);
    chk("R1 current", {mem[HDR + 6], mem[HDR + 7]}, 100);
    chk("R1 soft min", {mem[HDR + 8], mem[HDR + 9]}, 20);
    chk("R1 cap out", cap, 100);
    chk("R1 type out", ctype, 0);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VECS[i];
      automatic logic [7:0] rid = 8'h30 + 8'(i);
      automatic int ev0;
      load(v, rid);
      ev0 = ev_cnt;
      poll();
      if (v.cflag != 8'h80) begin
        chk("R2 rsp flag untouched", mem[RSP], v.rflag);
        chk("R2 cmd flag untouched", mem[CMD], v.cflag);
        chk("R2 no event", ev_cnt, ev0);
        chk("R2 cap unchanged", cap, v.cap);
        continue;
      end
      if (v.rflag == 8'h00) begin
        chk("R3 in progress flag", mem[RSP], 8'h02);
        chk("R3 cmd still pending", mem[CMD], 8'h80);
        chk("R3 no event", ev_cnt, ev0);
        poll();
      end
      chk("R10 rsp ready", mem[RSP], 8'h01);
      chk("R10 cmd cleared", mem[CMD], 8'h00);
      chk("R10 one event", ev_cnt, ev0 + 1);
      chk("R9 request id", mem[RSP + 1], rid);
      chk("R9 code", mem[RSP + 2], v.code);
      chk("R4 R5 R6 R7 R8 status", mem[RSP + 3], v.st);
      chk("R9 length", {mem[RSP + 4], mem[RSP + 5]}, v.rlen);
      if (v.rlen == 8'd2)
        chk("R9 data cap", {mem[RSP + 6], mem[RSP + 7]}, v.cap);
      chk("R6 R7 cap out", cap, v.cap);
      chk("R6 R7 type out", ctype, v.typ);
      chk("R13 header type", mem[HDR + 1], v.typ);
      chk("R13 header cap", {mem[HDR + 6], mem[HDR + 7]}, v.cap);
      chk("R10 data before ready", int'(t_dat < t_rdy), 1);
      chk("R10 ready before clear", int'(t_rdy < t_clr), 1);
      chk("R10 clear before event", int'(t_clr < t_evt), 1);
    end

    // R11: second tick during the in-progress poll is held and serviced
    begin
      automatic vec_t v = '{8'h80, 8'h00, 8'hD1, 16'd2, 16'd40, 8'h00, 8'd2, 16'd40, 8'h02};
      automatic int ev0;
      load(v, 8'h5A);
      ev0 = ev_cnt;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      chk("R11 first poll busy", int'(busy), 1);
      tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (3) @(negedge clk);
      wait_idle();
      repeat (4) @(negedge clk);
      wait_idle();
      @(negedge clk);
      chk("R11 held tick answered", mem[RSP], 8'h01);
      chk("R11 cap", cap, 40);
      chk("R11 event", ev_cnt, ev0 + 1);
    end

    chk("R12 no access while idle", viol, 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule